// File: doc/BRIEF.md
# Gray-Code Sequenced Intersection Lamp Controller

This block runs the lamps of a four-way crossing that has two directions of travel: north/south and east/west. A 4-bit state register steps through the sixteen codes of a reflected-binary (Gray) ordering. Each code is held for one timed interval. The interval length comes from a prescaler that counts system clock cycles. An optional enable input gates that count, so an external slow tick or a pause signal can stretch the interval. The six lamp lines are decoded from the present code alone. No other state feeds them.

One full turn of the sequence holds every code for one interval. Each direction gets six intervals of green, one interval of yellow and nine intervals of red. Two of the sixteen intervals show red in both directions, and these serve as safety clearances. With a 50 MHz clock, the default prescaler gives 5-second intervals and an 80-second cycle. A simulation can set the prescaler to a few clocks.

Top module: `tlc_gray_light`

## Requirements
- R1: When `rst` is high at a clock edge, the next state is code 0000 with the prescaler cleared. In that state only `ns_green` and `ew_red` are 1.
- R2: While `tick_en` stays high, the code advances exactly once every `CLK_PER_INTERVAL` clock edges. A full interval of enabled edges must pass after reset before the first advance.
- R3: The code steps through 0000, 0001, 0011, 0010, 0110, 0111, 0101, 0100, 1100, 1101, 1111, 1110, 1010, 1011, 1001, 1000 and then returns to 0000. Sequence position p is the index in this list (0 to 15).
- R4: Every advance changes exactly one bit of `code`.
- R5: A clock edge with `tick_en` low changes neither the code nor the prescaler count. After the pause, the interval resumes with its earlier partial count kept.
- R6: Lamp timing for north/south:
  - `ns_green` is 1 for positions 0 to 5.
  - `ns_yellow` is 1 at position 6 (code 0101).
  - `ns_red` is 1 for positions 7 to 15.
- R7: Lamp timing for east/west:
  - `ew_green` is 1 for positions 8 to 13.
  - `ew_yellow` is 1 at position 14 (code 1001).
  - `ew_red` is 1 for positions 0 to 7 and 15.
- R8: Exactly one lamp per direction is lit in every interval. The two greens are never lit together. Positions 7 (code 0100) and 15 (code 1000) are red in both directions.
- R9: The lamps are a function of `code` only. They change in the same cycle as the code, with no extra register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Prescaler count enable; tie high for free-running operation |
| code | output | 4 | Current Gray-sequence code |
| ns_red | output | 1 | North/south red lamp, 1 = lit |
| ns_yellow | output | 1 | North/south yellow lamp, 1 = lit |
| ns_green | output | 1 | North/south green lamp, 1 = lit |
| ew_red | output | 1 | East/west red lamp, 1 = lit |
| ew_yellow | output | 1 | East/west yellow lamp, 1 = lit |
| ew_green | output | 1 | East/west green lamp, 1 = lit |

## Verification
The assertions check several properties on every cycle:
- each direction shows exactly one lamp and the greens never overlap;
- each advance flips a single code bit, and the code wraps from 1000 to 0000;
- the prescaler count stays inside its range;
- a disabled cycle freezes the code;
- reset lands in code 0000.

The exact order of the sixteen codes, the green/yellow/red split at each position and the interval length in clock edges are shown only by the bench's scenarios. The same holds for a paused interval resuming its partial count and for a reset in mid-sequence restarting a whole interval.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    localparam int SEQ_W   = 4;
    localparam int SEQ_LEN = 1 << SEQ_W;

    typedef struct packed {
        logic red;
        logic yellow;
        logic green;
    } lamp_t;

    function automatic logic [SEQ_W-1:0] gray_to_bin(input logic [SEQ_W-1:0] g);
        logic [SEQ_W-1:0] b;
        b[SEQ_W-1] = g[SEQ_W-1];
        for (int i = SEQ_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic logic [SEQ_W-1:0] bin_to_gray(input logic [SEQ_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
    parameter int CLK_PER_INTERVAL = 250_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    output logic step
);
    localparam int CNT_W = (CLK_PER_INTERVAL > 1) ? $clog2(CLK_PER_INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_PER_INTERVAL - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_state_t;

    timer_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        step = tick_en && (st_q.cnt == LAST);
        if (rst) begin
            st_d.cnt = '0;
            step     = 1'b0;
        end else if (tick_en) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST);

    a_r5_cnt_frozen: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(st_q.cnt));

    a_r1_cnt_cleared: assert property (@(posedge clk)
        rst |=> st_q.cnt == '0);

endmodule

// File: rtl/tlc_gray_sequencer.sv
module tlc_gray_sequencer
    import tlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [SEQ_W-1:0] code
);
    localparam logic [SEQ_W-1:0] LAST_CODE = bin_to_gray(SEQ_W'(SEQ_LEN - 1));

    typedef struct packed {
        logic [SEQ_W-1:0] code;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.code = '0;
        end else if (step) begin
            st_d.code = bin_to_gray(gray_to_bin(st_q.code) + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign code = st_q.code;

    a_r4_single_bit_step: assert property (@(posedge clk) disable iff (rst)
        step |=> $countones(st_q.code ^ $past(st_q.code)) == 1);

    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (step && st_q.code == LAST_CODE) |=> st_q.code == '0);

    a_r1_code_cleared: assert property (@(posedge clk)
        rst |=> st_q.code == '0);

endmodule

// File: rtl/tlc_lamp_decode.sv
module tlc_lamp_decode
    import tlc_pkg::*;
#(
    parameter int GREEN_INTERVALS = 6
) (
    input  logic [SEQ_W-1:0] code,
    output lamp_t            ns,
    output lamp_t            ew
);
    localparam int HALF = SEQ_LEN / 2;
    localparam logic [SEQ_W-1:0] GREEN_END = SEQ_W'(GREEN_INTERVALS);
    localparam logic [SEQ_W-1:0] EW_OFFSET = SEQ_W'(HALF);

    logic [SEQ_W-1:0] pos_ns;
    logic [SEQ_W-1:0] pos_ew;

    always_comb begin
        pos_ns = gray_to_bin(code);
        pos_ew = pos_ns - EW_OFFSET;

        ns.green  = (pos_ns < GREEN_END);
        ns.yellow = (pos_ns == GREEN_END);
        ns.red    = (pos_ns > GREEN_END);

        ew.green  = (pos_ew < GREEN_END);
        ew.yellow = (pos_ew == GREEN_END);
        ew.red    = (pos_ew > GREEN_END);
    end

endmodule

// File: rtl/tlc_gray_light.sv
module tlc_gray_light
    import tlc_pkg::*;
#(
    parameter int CLK_PER_INTERVAL = 250_000_000,
    parameter int GREEN_INTERVALS  = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    output logic [3:0] code,
    output logic       ns_red,
    output logic       ns_yellow,
    output logic       ns_green,
    output logic       ew_red,
    output logic       ew_yellow,
    output logic       ew_green
);
    logic             step;
    logic [SEQ_W-1:0] code_q;
    lamp_t            ns_l;
    lamp_t            ew_l;

    tlc_interval_timer #(
        .CLK_PER_INTERVAL(CLK_PER_INTERVAL)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .step    (step)
    );

    tlc_gray_sequencer seq_i (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .code (code_q)
    );

    tlc_lamp_decode #(
        .GREEN_INTERVALS(GREEN_INTERVALS)
    ) dec_i (
        .code (code_q),
        .ns   (ns_l),
        .ew   (ew_l)
    );

    assign code      = code_q;
    assign ns_red    = ns_l.red;
    assign ns_yellow = ns_l.yellow;
    assign ns_green  = ns_l.green;
    assign ew_red    = ew_l.red;
    assign ew_yellow = ew_l.yellow;
    assign ew_green  = ew_l.green;

    a_r8_ns_one_lamp: assert property (@(posedge clk) disable iff (rst)
        $countones({ns_red, ns_yellow, ns_green}) == 1);

    a_r8_ew_one_lamp: assert property (@(posedge clk) disable iff (rst)
        $countones({ew_red, ew_yellow, ew_green}) == 1);

    a_r8_greens_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ns_green && ew_green));

    a_r5_code_holds: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(code));

    a_r1_reset_lamps: assert property (@(posedge clk)
        rst |=> (ns_green && ew_red && !ns_red && !ns_yellow && !ew_yellow && !ew_green));

endmodule

// File: tb/tlc_gray_light_tb.sv
module tlc_gray_light_tb_top;

    localparam int CPI = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic [3:0] code;
    logic       ns_red, ns_yellow, ns_green, ew_red, ew_yellow, ew_green;

    int checks = 0;
    int failures = 0;

    logic [3:0] seq_tab [16] = '{4'b0000, 4'b0001, 4'b0011, 4'b0010,
                                 4'b0110, 4'b0111, 4'b0101, 4'b0100,
                                 4'b1100, 4'b1101, 4'b1111, 4'b1110,
                                 4'b1010, 4'b1011, 4'b1001, 4'b1000};

    always #10 clk = ~clk;

    tlc_gray_light #(
        .CLK_PER_INTERVAL(CPI),
        .GREEN_INTERVALS (6)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .code      (code),
        .ns_red    (ns_red),
        .ns_yellow (ns_yellow),
        .ns_green  (ns_green),
        .ew_red    (ew_red),
        .ew_yellow (ew_yellow),
        .ew_green  (ew_green)
    );

    // {ns_red, ns_yellow, ns_green, ew_red, ew_yellow, ew_green}
    function automatic logic [5:0] exp_lamps(input int p);
        logic [2:0] n, e;
        if (p <= 5)      n = 3'b001;
        else if (p == 6) n = 3'b010;
        else             n = 3'b100;
        if (p >= 8 && p <= 13) e = 3'b001;
        else if (p == 14)      e = 3'b010;
        else                   e = 3'b100;
        return {n, e};
    endfunction

    function automatic logic [5:0] lamps();
        return {ns_red, ns_yellow, ns_green, ew_red, ew_yellow, ew_green};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tick_en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(code == 4'b0000, "R1", "code after reset", code, 0);
        chk(lamps() == 6'b001_100, "R1", "lamps after reset", lamps(), 6'b001_100);
    endtask

    task automatic t_interval_length();
        do_reset();
        repeat (CPI - 1) @(negedge clk);
        chk(code == 4'b0000, "R2", "code one edge before interval end", code, 0);
        @(negedge clk);
        chk(code == 4'b0001, "R2", "code at interval end", code, 1);
        repeat (CPI - 1) @(negedge clk);
        chk(code == 4'b0001, "R2", "second interval early", code, 1);
        @(negedge clk);
        chk(code == 4'b0011, "R2", "second interval end", code, 3);
    endtask

    task automatic t_full_cycle();
        logic [3:0] prev;
        do_reset();
        prev = code;
        for (int i = 0; i <= 16; i++) begin
            int p = i % 16;
            chk(code == seq_tab[p], "R3", $sformatf("code at position %0d", p), code, seq_tab[p]);
            chk(lamps() == exp_lamps(p), "R6", $sformatf("ns/ew lamps at position %0d (R7 R9)", p),
                lamps(), exp_lamps(p));
            if (i > 0)
                chk($countones(code ^ prev) == 1, "R4", "bits changed per step",
                    $countones(code ^ prev), 1);
            if (p == 7 || p == 15)
                chk(ns_red && ew_red, "R8", $sformatf("all-red at position %0d", p),
                    {ns_red, ew_red}, 2'b11);
            chk(!(ns_green && ew_green), "R8", "greens exclusive", {ns_green, ew_green}, 0);
            prev = code;
            repeat (CPI) @(negedge clk);
        end
    endtask

    task automatic t_pause_resume();
        do_reset();
        repeat (CPI) @(negedge clk);
        chk(code == 4'b0001, "R5", "setup position 1", code, 1);
        repeat (2) @(negedge clk);
        tick_en = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(code == 4'b0001, "R5", "code frozen while paused", code, 1);
        end
        chk(lamps() == exp_lamps(1), "R5", "lamps frozen while paused", lamps(), exp_lamps(1));
        tick_en = 1'b1;
        @(negedge clk);
        chk(code == 4'b0001, "R5", "partial count kept, not yet done", code, 1);
        @(negedge clk);
        chk(code == 4'b0011, "R5", "advance after remaining edges", code, 3);
    endtask

    task automatic t_midseq_reset();
        do_reset();
        repeat (CPI * 9 + 2) @(negedge clk);
        chk(code == seq_tab[9], "R3", "position 9 before reset", code, seq_tab[9]);
        do_reset();
        chk(code == 4'b0000, "R1", "code after mid-sequence reset", code, 0);
        chk(lamps() == 6'b001_100, "R1", "lamps after mid-sequence reset", lamps(), 6'b001_100);
        repeat (CPI - 1) @(negedge clk);
        chk(code == 4'b0000, "R2", "prescaler cleared by reset", code, 0);
        @(negedge clk);
        chk(code == 4'b0001, "R2", "first advance after reset", code, 1);
    endtask

    task automatic t_yellow_codes();
        do_reset();
        repeat (CPI * 6) @(negedge clk);
        chk(code == 4'b0101 && ns_yellow && ew_red, "R6", "ns yellow at 0101",
            {code, lamps()}, {4'b0101, 6'b010_100});
        repeat (CPI * 8) @(negedge clk);
        chk(code == 4'b1001 && ew_yellow && ns_red, "R7", "ew yellow at 1001",
            {code, lamps()}, {4'b1001, 6'b100_010});
    endtask

    initial begin
        t_reset_state();
        t_interval_length();
        t_full_cycle();
        t_pause_resume();
        t_midseq_reset();
        t_yellow_codes();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule